// File: doc/BRIEF.md
# Upset-Direction Shift Chain Monitor

This block is a radiation test structure. It holds a long chain of flip-flops loaded with a four-bit repeating pattern. The chain is left untouched for a programmable number of clock cycles. After that exposure it is clocked out and every bit is checked against the pattern. A bit that reads 1 where 0 was written adds to a rise counter. A bit that reads 0 where 1 was written adds to a fall counter. Readout and refill happen in the same pass: while the old contents leave the chain, fresh pattern bits enter it. This lets the next exposure start without any gap.

While `run` is high the block repeats the exposure-and-scan cycle without stopping. A one-cycle `done` pulse marks the end of every scan. The two counters then hold their values until the next scan begins, so they can be read at leisure during the exposure that follows.

A hit-injection stream port stands in for the effect of the beam. It flips one chosen stage of the chain. The port uses valid/ready: `hit_ready` is high only during exposure, and a hit is taken on any cycle where both signals are high. The block holds no queue. A producer that has a hit pending keeps `hit_valid` high with a stable index until the hit is taken.

Top module: `seu_chain_monitor`

## Requirements
- R1: After reset both counters read 0, `done` is 0 and `hit_ready` is 0, and the block stays idle while `run` is low.
- R2: When `run` is seen high in idle, the block fills the chain for CHAIN_LEN cycles without comparing and without `done`, then starts exposure. The first `done` therefore comes 2*CHAIN_LEN + max(interval,1) + 1 cycles after the edge that samples `run`.
- R3: Exposure lasts max(interval,1) cycles and the chain holds its contents throughout. Between two consecutive `done` pulses there are exactly max(interval,1) + CHAIN_LEN cycles. `interval` is sampled when each exposure begins.
- R4: A hit is accepted when `hit_valid` and `hit_ready` are both high, and `hit_ready` is high only during exposure. An accepted hit inverts the stage that is read out at position `hit_index` in the next scan, with position 0 read out first. An index of CHAIN_LEN or more has no effect.
- R5: The bit at readout position k is expected to be 0 when k mod 4 is 0 or 1, and 1 when k mod 4 is 2 or 3. A 1 read where 0 is expected increments `rise_count`, and a 0 read where 1 is expected increments `fall_count`.
- R6: Both counters clear when a scan starts. They change only during a scan, and they keep their values through the following exposure and through idle.
- R7: Each counter saturates at its all-ones value and does not wrap.
- R8: `done` is high for exactly one cycle, in the cycle after the last shift of each scan. The counter values it marks are final.
- R9: `run` is checked at the end of each scan. If it is low, the block finishes the current pass and goes idle. Neither `done` nor `hit_ready` rises again until `run` returns, and that return begins a new fill.
- R10: Two accepted hits on the same stage within one exposure restore the stage, so nothing is counted for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Keeps the exposure/scan cycle going while high |
| interval | input | IVL_W | Exposure length in clock cycles (0 acts as 1) |
| hit_valid | input | 1 | Hit request valid |
| hit_ready | output | 1 | Hit can be accepted (exposure only) |
| hit_index | input | IDX_W | Readout position of the stage to invert |
| rise_count | output | CNT_W | 0-to-1 upsets found in the last scan |
| fall_count | output | CNT_W | 1-to-0 upsets found in the last scan |
| done | output | 1 | One-cycle pulse at the end of each scan |

## Verification
A fault in the sequencer's step or exposure counter shows up first in the spacing of `done`. The bench measures that spacing to the exact cycle, so any such fault is caught within one pass. A stage that is mapped to the wrong position, or a pattern phase that is off, moves an upset into the wrong counter or creates false counts. Every scan reveals this, either in the pass that follows a directed hit or in a clean pass that should read zero. A counter that wraps, clears at the wrong time or drifts during exposure shows in the values read after `done` and in samples taken during the next exposure.

// File: rtl/seu_mon_pkg.sv
package seu_mon_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FILL   = 2'd1,
    ST_EXPOSE = 2'd2,
    ST_SCAN   = 2'd3
  } mon_state_e;
endpackage

// File: rtl/seu_pattern_gen.sv
// Expected/fill bit for the current shift step; phase restarts with the step count.
module seu_pattern_gen #(
  parameter int STEP_W  = 11,
  parameter int PAT_LEN = 4,
  parameter logic [PAT_LEN-1:0] PATTERN = 4'b1100
) (
  input  logic [STEP_W-1:0] step,
  output logic              pat_bit
);
  localparam int PH_W = (PAT_LEN > 1) ? $clog2(PAT_LEN) : 1;
  logic [STEP_W-1:0] phase_full;
  assign phase_full = step % STEP_W'(PAT_LEN);
  assign pat_bit    = PATTERN[phase_full[PH_W-1:0]];
endmodule

// File: rtl/seu_chain.sv
// Chain under test: shifts toward the top stage, holds otherwise, one stage invertible.
module seu_chain #(
  parameter int CHAIN_LEN = 1500,
  parameter int IDX_W     = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             in_bit,
  input  logic             flip_en,
  input  logic [IDX_W-1:0] flip_pos,
  output logic             out_bit
);
  logic [CHAIN_LEN-1:0] q;

  for (genvar i = 0; i < CHAIN_LEN; i++) begin : g_stage
    logic nxt_shift;
    if (i == 0) begin : g_head
      assign nxt_shift = in_bit;
    end else begin : g_body
      assign nxt_shift = q[i-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q[i] <= 1'b0;
      else if (shift_en)
        q[i] <= nxt_shift;
      else if (flip_en && flip_pos == IDX_W'(i))
        q[i] <= ~q[i];
    end
  end

  assign out_bit = q[CHAIN_LEN-1];
endmodule

// File: rtl/seu_flip_tally.sv
module seu_flip_tally #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      count <= '0;
    else if (clr)
      count <= '0;
    else if (inc && count != TOP)
      count <= count + 1'b1;
  end
endmodule

// File: rtl/seu_seq.sv
module seu_seq
  import seu_mon_pkg::*;
#(
  parameter int CHAIN_LEN = 1500,
  parameter int IVL_W     = 32,
  parameter int STEP_W    = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [IVL_W-1:0]  interval,
  output mon_state_e        st,
  output logic [STEP_W-1:0] step,
  output logic              shift_en,
  output logic              clr,
  output logic              done
);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(CHAIN_LEN - 1);
  logic [IVL_W-1:0] remain;
  logic [IVL_W-1:0] ivl_eff;
  logic             expose_end;

  assign ivl_eff    = (interval == '0) ? IVL_W'(1) : interval;
  assign expose_end = (st == ST_EXPOSE) && (remain <= IVL_W'(1));
  assign shift_en   = (st == ST_FILL) || (st == ST_SCAN);
  assign clr        = expose_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      step   <= '0;
      remain <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: if (run) begin
          st   <= ST_FILL;
          step <= '0;
        end
        ST_FILL: if (step == LAST) begin
          st     <= ST_EXPOSE;
          remain <= ivl_eff;
        end else begin
          step <= step + 1'b1;
        end
        ST_EXPOSE: if (expose_end) begin
          st   <= ST_SCAN;
          step <= '0;
        end else begin
          remain <= remain - 1'b1;
        end
        ST_SCAN: if (step == LAST) begin
          done <= 1'b1;
          if (run) begin
            st     <= ST_EXPOSE;
            remain <= ivl_eff;
          end else begin
            st <= ST_IDLE;
          end
        end else begin
          step <= step + 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/seu_chain_monitor.sv
module seu_chain_monitor
  import seu_mon_pkg::*;
#(
  parameter int CHAIN_LEN = 1500,
  parameter int CNT_W     = 16,
  parameter int IVL_W     = 32,
  parameter int IDX_W     = $clog2(CHAIN_LEN) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [IVL_W-1:0] interval,
  input  logic             hit_valid,
  output logic             hit_ready,
  input  logic [IDX_W-1:0] hit_index,
  output logic [CNT_W-1:0] rise_count,
  output logic [CNT_W-1:0] fall_count,
  output logic             done
);
  localparam int STEP_W = $clog2(CHAIN_LEN);

  mon_state_e        st;
  logic [STEP_W-1:0] step;
  logic              shift_en, clr, pat_bit, out_bit;
  logic              hit_take, scanning, rise_inc, fall_inc;
  logic [IDX_W-1:0]  flip_pos;

  seu_seq #(.CHAIN_LEN(CHAIN_LEN), .IVL_W(IVL_W), .STEP_W(STEP_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .run(run), .interval(interval),
    .st(st), .step(step), .shift_en(shift_en), .clr(clr), .done(done)
  );

  seu_pattern_gen #(.STEP_W(STEP_W), .PAT_LEN(4), .PATTERN(4'b1100)) u_pat (
    .step(step), .pat_bit(pat_bit)
  );

  assign hit_ready = (st == ST_EXPOSE);
  assign hit_take  = hit_valid && hit_ready && (hit_index < IDX_W'(CHAIN_LEN));
  assign flip_pos  = IDX_W'(CHAIN_LEN - 1) - hit_index;

  seu_chain #(.CHAIN_LEN(CHAIN_LEN), .IDX_W(IDX_W)) u_chain (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .in_bit(pat_bit),
    .flip_en(hit_take), .flip_pos(flip_pos), .out_bit(out_bit)
  );

  assign scanning = (st == ST_SCAN);
  assign rise_inc = scanning && out_bit && !pat_bit;
  assign fall_inc = scanning && !out_bit && pat_bit;

  seu_flip_tally #(.CNT_W(CNT_W)) u_rise (
    .clk(clk), .rst_n(rst_n), .clr(clr), .inc(rise_inc), .count(rise_count)
  );
  seu_flip_tally #(.CNT_W(CNT_W)) u_fall (
    .clk(clk), .rst_n(rst_n), .clr(clr), .inc(fall_inc), .count(fall_count)
  );
endmodule

// File: rtl/seu_chain_monitor_chk.sv
module seu_chain_monitor_chk
  import seu_mon_pkg::*;
#(
  parameter int CHAIN_LEN = 1500,
  parameter int CNT_W     = 16
) (
  input logic             clk,
  input logic             rst_n,
  input mon_state_e       st,
  input logic             done,
  input logic             hit_ready,
  input logic [CNT_W-1:0] rise_count,
  input logic [CNT_W-1:0] fall_count
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_fill_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FILL) |-> !done);

  p_hold_expose_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_EXPOSE && $past(st) == ST_EXPOSE) |-> ($stable(rise_count) && $stable(fall_count)));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && $past(st) == ST_IDLE) |-> (!done && !hit_ready));

  p_rise_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SCAN && rise_count == TOP) |=> rise_count == TOP);

  p_fall_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SCAN && fall_count == TOP) |=> fall_count == TOP);

  p_rise_mono_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SCAN && $past(st) == ST_SCAN) |-> rise_count >= $past(rise_count));

  p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (32'(rise_count) + 32'(fall_count)) <= 32'(CHAIN_LEN));
endmodule

bind seu_chain_monitor seu_chain_monitor_chk #(.CHAIN_LEN(CHAIN_LEN), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .st(st), .done(done), .hit_ready(hit_ready),
  .rise_count(rise_count), .fall_count(fall_count)
);

// File: tb/seu_chain_monitor_bench.sv
module seu_chain_monitor_bench;
  localparam int L     = 1500;
  localparam int CW    = 4;
  localparam int IW    = 32;
  localparam int XW    = $clog2(L) + 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          run = 1'b0;
  logic [IW-1:0] interval = 32'd200;
  logic          hit_valid = 1'b0;
  logic          hit_ready;
  logic [XW-1:0] hit_index = '0;
  logic [CW-1:0] rise_count, fall_count;
  logic          done;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  seu_chain_monitor #(.CHAIN_LEN(L), .CNT_W(CW), .IVL_W(IW)) u_seu_chain_monitor (
    .clk(clk), .rst_n(rst_n), .run(run), .interval(interval),
    .hit_valid(hit_valid), .hit_ready(hit_ready), .hit_index(hit_index),
    .rise_count(rise_count), .fall_count(fall_count), .done(done)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_done(output int c);
    c = 0;
    do begin
      @(negedge clk);
      c++;
    end while (!done && c < 20000);
  endtask

  task automatic hit(input int idx);
    hit_valid = 1'b1;
    hit_index = XW'(idx);
    @(negedge clk);
    hit_valid = 1'b0;
  endtask

  task automatic t_reset;
    repeat (5) @(negedge clk);
    check("R1 rise", rise_count, 0);
    check("R1 fall", fall_count, 0);
    check("R1 done", done, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check("R1 idle ready", hit_ready, 0);
  endtask

  task automatic t_start;
    int c;
    run = 1'b1;
    wait_done(c);
    check("R2 first done latency", c, 2 * L + 200 + 1);
    check("R5 clean rise", rise_count, 0);
    check("R5 clean fall", fall_count, 0);
  endtask

  task automatic t_rise;
    int c;
    hit(0); hit(1); hit(4);          // expected 0 at these positions
    wait_done(c);
    check("R5 rise hits", rise_count, 3);
    check("R5 rise fall", fall_count, 0);
  endtask

  task automatic t_fall;
    int c;
    hit(2); hit(3); hit(1499);       // expected 1 (mod 4 = 2,3,3)
    wait_done(c);
    check("R5 fall hits", fall_count, 3);
    check("R6 rise cleared", rise_count, 0);
  endtask

  task automatic t_cancel;
    int c;
    hit(5); hit(5); hit(6);
    wait_done(c);
    check("R10 double hit rise", rise_count, 0);
    check("R10 single fall", fall_count, 1);
  endtask

  task automatic t_range;
    int c;
    hit(1500); hit(4095);
    wait_done(c);
    check("R4 out of range rise", rise_count, 0);
    check("R4 out of range fall", fall_count, 0);
  endtask

  task automatic t_stable;
    int c;
    int bad = 0;
    hit(8);
    wait_done(c);
    check("R5 single rise", rise_count, 1);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (rise_count != 1 || fall_count != 0) bad++;
    end
    check("R6 stable in exposure", bad, 0);
    wait_done(c);
  endtask

  task automatic t_saturate;
    int c;
    for (int m = 0; m < 10; m++) begin
      hit(4 * m);
      hit(4 * m + 1);
    end
    wait_done(c);
    check("R7 rise saturates", rise_count, 15);
    check("R7 fall", fall_count, 0);
  endtask

  task automatic t_period;
    int c;
    interval = 32'd0;
    wait_done(c);
    wait_done(c);
    check("R3 period interval 0", c, 1 + L);
    interval = 32'd37;
    wait_done(c);
    wait_done(c);
    check("R3 period interval 37", c, 37 + L);
    interval = 32'd200;
    wait_done(c);
  endtask

  task automatic t_stop_restart;
    int c;
    int bad = 0;
    hit(2);
    run = 1'b0;
    wait_done(c);
    check("R9 final pass fall", fall_count, 1);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (done || hit_ready) bad++;
    end
    check("R9 idle no done/ready", bad, 0);
    check("R6 held in idle", fall_count, 1);
    run = 1'b1;
    wait_done(c);
    check("R2 restart latency", c, 2 * L + 200 + 1);
    check("R6 restart cleared", fall_count, 0);
  endtask

  initial begin
    #(4 * 190000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_start();
    t_rise();
    t_fall();
    t_cancel();
    t_range();
    t_stable();
    t_saturate();
    t_period();
    t_stop_restart();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule